// File: doc/BRIEF.md
# Adaptive Burst Pulse-Count Regulator

This block sets how many switching pulses a light-load burst packet carries, so that packets repeat often enough to stay above the audible band. It counts clock cycles between successive packet-start strobes. The count taken at each strobe is a period, and a longer period means a lower burst frequency. When the period shows the frequency has dropped to the low threshold, the pulse-count target falls by one. When the frequency has reached the active upper threshold, the target rises by one.

The ceiling on the target and the upper threshold both depend on an output-voltage mode. Two comparator results are sampled on a strobe taken at the high-side falling edge. The two trip points are apart, which gives the mode hysteresis. The block also keeps a short history of packets flagged as merged with their neighbour. When merging becomes frequent, it raises a request to sink current from the burst-threshold reference. Frequencies become period counts at elaboration, from a parameterised clock rate.

Top module: `burstcnt_regulator`

## Requirements
- R1: After reset, pulse_target is 5, sink_req is 0, the voltage mode is low and no reference period exists.
- R2: Every cycle with pkt_start high records a period, P = clock cycles since the previous pkt_start. The first pkt_start after reset only sets the reference and leaves pulse_target unchanged. pulse_target changes only on a pkt_start or a mode change.
- R3: If P >= CLK_HZ/25000 (integer division; frequency at or below 25 kHz), pulse_target falls by one on the clock edge that samples pkt_start. It never goes below 1.
- R4: If P <= the active upper period (and R3 does not apply), pulse_target rises by one on that same edge. It never goes above the current ceiling.
- R5: If P lies strictly between the active upper period and CLK_HZ/25000, pulse_target holds.
- R6: In low-voltage mode the ceiling is 5 and the upper period is CLK_HZ/50000.
- R7: In high-voltage mode the ceiling is 9. The upper period is CLK_HZ/50000 while pulse_target <= 3, and CLK_HZ/34000 while pulse_target > 3. The value of pulse_target before the step decides which applies.
- R8: On a cycle with vs_strobe high, vs_under high selects low-voltage mode (vs_under wins if both are high). Otherwise vs_over high selects high-voltage mode, and with neither high the mode is kept. Without vs_strobe, vs_under and vs_over are ignored.
- R9: A mode change that lowers the ceiling below pulse_target clamps pulse_target to the new ceiling on the same edge as the mode change.
- R10: On a pkt_start, the window holds the current pkt_merged and the flags of the 7 previous packet starts. If this window holds 2 or more set flags, sink_req is 1 from the next cycle.
- R11: Once asserted, sink_req stays 1 until sink_clear, or until a pkt_start whose 8-entry window holds no set flag.
- R12: sink_clear drops sink_req and empties the merged-flag history on the next edge. It takes priority over a pkt_start in the same cycle, whose pkt_merged flag is then discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | One-cycle strobe at each burst packet start |
| pkt_merged | input | 1 | Packet is merged with its neighbour; valid with pkt_start |
| vs_strobe | input | 1 | Output-voltage sample strobe (high-side falling edge) |
| vs_under | input | 1 | Sampled voltage below the lower trip point |
| vs_over | input | 1 | Sampled voltage above the upper trip point |
| sink_clear | input | 1 | Clears the sink request and merged history |
| pulse_target | output | PCNT_W (4) | Pulses per burst packet target |
| sink_req | output | 1 | Request to sink current from the burst reference |

## Verification
The stepping rule is driven with packet gaps placed on both sides of each period boundary: exactly the low period, one below it, and the two upper periods and their neighbours. This separates an off-by-one in a comparison from a wrong threshold. Runs of short and long gaps walk the target into its floor and both ceilings. A gap between the two upper periods, given at counts 3 and 4 in high mode, shows whether the split threshold follows the count. Mode strobes with one, both or neither comparator set, and comparator changes without a strobe, check the hysteresis and the clamp. Merged flags spaced 4, 7 and 8 starts apart mark the edge of the sliding window. A randomized phase then mixes all of these against a cycle-level model.

// File: rtl/burstcnt_pkg.sv
package burstcnt_pkg;

   typedef enum logic {
      VMODE_LOW  = 1'b0,
      VMODE_HIGH = 1'b1
   } vmode_t;

   // Clock cycles in one period of a frequency, truncated.
   function automatic int unsigned hz_to_cycles(input longint unsigned clk_hz,
                                                input longint unsigned f_hz);
      return int'(clk_hz / f_hz);
   endfunction

endpackage

// File: rtl/burstcnt_period_meter.sv
module burstcnt_period_meter #(
   parameter int PER_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_start,
   output logic             meas_valid,
   output logic [PER_W-1:0] meas_per
);
   localparam logic [PER_W-1:0] PER_SAT = {PER_W{1'b1}};

   logic [PER_W-1:0] cnt_q;
   logic             have_ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         have_ref_q <= 1'b0;
      end else if (pkt_start) begin
         cnt_q      <= PER_W'(1);
         have_ref_q <= 1'b1;
      end else if (cnt_q != PER_SAT) begin
         cnt_q <= cnt_q + PER_W'(1);
      end
   end

   assign meas_valid = pkt_start & have_ref_q;
   assign meas_per   = cnt_q;

   AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> meas_per != '0) else $error("zero period measured"); // R2

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_start && cnt_q == PER_SAT) |=> cnt_q == PER_SAT) else $error("period counter wrapped"); // R3

   AST_FIRST_NO_REF: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |=> have_ref_q) else $error("reference not kept"); // R2

endmodule

// File: rtl/burstcnt_vs_mode.sv
module burstcnt_vs_mode
   import burstcnt_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   vs_strobe,
   input  logic   vs_under,
   input  logic   vs_over,
   output vmode_t mode_q,
   output vmode_t mode_d
);
   always_comb begin
      mode_d = mode_q;
      if (vs_strobe) begin
         if (vs_under)
            mode_d = VMODE_LOW;
         else if (vs_over)
            mode_d = VMODE_HIGH;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= VMODE_LOW;
      else        mode_q <= mode_d;
   end

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !vs_strobe |=> $stable(mode_q)) else $error("mode moved without strobe"); // R8

   AST_MODE_UNDER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_strobe && vs_under) |=> mode_q == VMODE_LOW) else $error("under not honoured"); // R8

   AST_MODE_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_strobe && !vs_under && !vs_over) |=> $stable(mode_q)) else $error("hysteresis band moved mode"); // R8

endmodule

// File: rtl/burstcnt_stepper.sv
module burstcnt_stepper
   import burstcnt_pkg::*;
#(
   parameter int MAX_LO      = 5,
   parameter int MAX_HI      = 9,
   parameter int SPLIT_CNT   = 3,
   parameter int PCNT_W      = 4,
   parameter int PER_W       = 10,
   parameter int LR_PER      = 400,
   parameter int UP_FAST_PER = 200,
   parameter int UP_SLOW_PER = 294
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              meas_valid,
   input  logic [PER_W-1:0]  meas_per,
   input  vmode_t            mode_q,
   input  vmode_t            mode_d,
   output logic [PCNT_W-1:0] count_q
);
   localparam logic [PCNT_W-1:0] CNT_ONE = PCNT_W'(1);
   localparam logic [PCNT_W-1:0] CNT_LO  = PCNT_W'(MAX_LO);
   localparam logic [PCNT_W-1:0] CNT_HI  = PCNT_W'(MAX_HI);
   localparam logic [PCNT_W-1:0] CNT_SPL = PCNT_W'(SPLIT_CNT);
   localparam logic [PER_W-1:0]  P_LR    = PER_W'(LR_PER);
   localparam logic [PER_W-1:0]  P_FAST  = PER_W'(UP_FAST_PER);
   localparam logic [PER_W-1:0]  P_SLOW  = PER_W'(UP_SLOW_PER);

   function automatic logic [PCNT_W-1:0] ceil_of(input vmode_t m);
      return (m == VMODE_HIGH) ? CNT_HI : CNT_LO;
   endfunction

   logic [PER_W-1:0]  up_per;
   logic [PCNT_W-1:0] cur_ceil;
   logic [PCNT_W-1:0] nxt_ceil;
   logic [PCNT_W-1:0] stepped;
   logic [PCNT_W-1:0] count_d;
   logic              go_down;
   logic              go_up;

   // Upper threshold: split by count only when the split point lies below the ceiling.
   generate
      if (SPLIT_CNT >= MAX_HI) begin : g_up_single
         assign up_per = P_FAST;
      end else begin : g_up_split
         assign up_per = (mode_q == VMODE_HIGH && count_q > CNT_SPL) ? P_SLOW : P_FAST;
      end
   endgenerate

   assign cur_ceil = ceil_of(mode_q);
   assign nxt_ceil = ceil_of(mode_d);
   assign go_down  = meas_valid && (meas_per >= P_LR) && (count_q > CNT_ONE);
   assign go_up    = meas_valid && (meas_per < P_LR) && (meas_per <= up_per) &&
                     (count_q < cur_ceil);

   always_comb begin
      stepped = count_q;
      if (go_down)
         stepped = count_q - CNT_ONE;
      else if (go_up)
         stepped = count_q + CNT_ONE;
      count_d = (stepped > nxt_ceil) ? nxt_ceil : stepped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= CNT_LO;
      else        count_q <= count_d;
   end

   AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      count_q >= CNT_ONE) else $error("count below one"); // R3

   AST_COUNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= cur_ceil) else $error("count above ceiling"); // R9

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && mode_d == mode_q) |=>
         (count_q == $past(count_q) || count_q == $past(count_q) + CNT_ONE ||
          count_q + CNT_ONE == $past(count_q))) else $error("step larger than one"); // R4

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!meas_valid && mode_d == mode_q) |=> $stable(count_q)) else $error("count moved while idle"); // R2

endmodule

// File: rtl/burstcnt_bundle_watch.sv
module burstcnt_bundle_watch #(
   parameter int WIN  = 8,
   parameter int HITS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pkt_start,
   input  logic pkt_merged,
   input  logic sink_clear,
   output logic sink_req
);
   localparam int HIST_W = WIN - 1;
   localparam int CW     = $clog2(WIN + 1);

   logic [HIST_W-1:0] hist_q;
   logic [WIN-1:0]    window;
   logic [CW-1:0]     hits;
   logic              shift_en;

   assign shift_en = pkt_start & ~sink_clear;
   assign window   = {hist_q, pkt_merged};

   generate
      for (genvar i = 0; i < HIST_W; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)          hist_q[i] <= 1'b0;
               else if (sink_clear) hist_q[i] <= 1'b0;
               else if (shift_en)   hist_q[i] <= pkt_merged;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)          hist_q[i] <= 1'b0;
               else if (sink_clear) hist_q[i] <= 1'b0;
               else if (shift_en)   hist_q[i] <= hist_q[i-1];
            end
         end
      end
   endgenerate

   always_comb begin
      hits = '0;
      for (int k = 0; k < WIN; k++)
         hits = hits + CW'(window[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sink_req <= 1'b0;
      else if (sink_clear)
         sink_req <= 1'b0;
      else if (shift_en) begin
         if (hits >= CW'(HITS))
            sink_req <= 1'b1;
         else if (hits == '0)
            sink_req <= 1'b0;
      end
   end

   AST_SINK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      sink_clear |=> (!sink_req && hist_q == '0)) else $error("clear not honoured"); // R12

   AST_SINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_start && !sink_clear) |=> $stable(sink_req)) else $error("sink moved without start"); // R11

   AST_SINK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && $countones(window) >= HITS) |=> sink_req) else $error("sink not raised"); // R10

endmodule

// File: rtl/burstcnt_regulator.sv
module burstcnt_regulator
   import burstcnt_pkg::*;
#(
   parameter longint unsigned CLK_HZ         = 10_000_000,
   parameter longint unsigned F_LOW_HZ       = 25_000,
   parameter longint unsigned F_UP_FAST_HZ   = 50_000,
   parameter longint unsigned F_UP_SLOW_HZ   = 34_000,
   parameter int              MAX_LO         = 5,
   parameter int              MAX_HI         = 9,
   parameter int              SPLIT_CNT      = 3,
   parameter int              PCNT_W         = 4,
   parameter int              BUNDLE_WIN     = 8,
   parameter int              BUNDLE_HITS    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_start,
   input  logic              pkt_merged,
   input  logic              vs_strobe,
   input  logic              vs_under,
   input  logic              vs_over,
   input  logic              sink_clear,
   output logic [PCNT_W-1:0] pulse_target,
   output logic              sink_req
);
   localparam int LR_PER      = int'(hz_to_cycles(CLK_HZ, F_LOW_HZ));
   localparam int UP_FAST_PER = int'(hz_to_cycles(CLK_HZ, F_UP_FAST_HZ));
   localparam int UP_SLOW_PER = int'(hz_to_cycles(CLK_HZ, F_UP_SLOW_HZ));
   localparam int PER_W       = $clog2(LR_PER + 1) + 1;

   generate
      if (MAX_LO < 1 || MAX_LO > MAX_HI) begin : g_bad_ceil
         $error("ceilings must satisfy 1 <= MAX_LO <= MAX_HI");
      end
      if (MAX_HI >= (1 << PCNT_W)) begin : g_bad_width
         $error("PCNT_W too narrow for MAX_HI");
      end
      if (!(F_LOW_HZ < F_UP_SLOW_HZ && F_UP_SLOW_HZ <= F_UP_FAST_HZ)) begin : g_bad_freq
         $error("thresholds must be ordered low < slow-upper <= fast-upper");
      end
      if (UP_FAST_PER < 1) begin : g_bad_clk
         $error("clock too slow for the upper threshold");
      end
      if (BUNDLE_WIN < 2 || BUNDLE_HITS < 1 || BUNDLE_HITS > BUNDLE_WIN) begin : g_bad_win
         $error("merged-packet window parameters out of range");
      end
   endgenerate

   logic             meas_valid;
   logic [PER_W-1:0] meas_per;
   vmode_t           mode_q;
   vmode_t           mode_d;

   burstcnt_period_meter #(
      .PER_W (PER_W)
   ) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .pkt_start  (pkt_start),
      .meas_valid (meas_valid),
      .meas_per   (meas_per)
   );

   burstcnt_vs_mode u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .vs_strobe (vs_strobe),
      .vs_under  (vs_under),
      .vs_over   (vs_over),
      .mode_q    (mode_q),
      .mode_d    (mode_d)
   );

   burstcnt_stepper #(
      .MAX_LO      (MAX_LO),
      .MAX_HI      (MAX_HI),
      .SPLIT_CNT   (SPLIT_CNT),
      .PCNT_W      (PCNT_W),
      .PER_W       (PER_W),
      .LR_PER      (LR_PER),
      .UP_FAST_PER (UP_FAST_PER),
      .UP_SLOW_PER (UP_SLOW_PER)
   ) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .meas_valid (meas_valid),
      .meas_per   (meas_per),
      .mode_q     (mode_q),
      .mode_d     (mode_d),
      .count_q    (pulse_target)
   );

   burstcnt_bundle_watch #(
      .WIN  (BUNDLE_WIN),
      .HITS (BUNDLE_HITS)
   ) u_bundle (
      .clk        (clk),
      .rst_n      (rst_n),
      .pkt_start  (pkt_start),
      .pkt_merged (pkt_merged),
      .sink_clear (sink_clear),
      .sink_req   (sink_req)
   );

   AST_MODE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_strobe && vs_under && !pkt_start) |=> pulse_target <= PCNT_W'(MAX_LO)) else $error("clamp missed"); // R9

endmodule

// File: tb/test_burstcnt_regulator.sv
`timescale 1ns/1ps
module test_burstcnt_regulator;
   localparam int CLK_HZ = 10_000_000;
   localparam int LR     = CLK_HZ / 25000;
   localparam int UPF    = CLK_HZ / 50000;
   localparam int UPS    = CLK_HZ / 34000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_start = 1'b0, pkt_merged = 1'b0, vs_strobe = 1'b0;
   logic       vs_under = 1'b0, vs_over = 1'b0, sink_clear = 1'b0;
   logic [3:0] pulse_target;
   logic       sink_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   int m_cnt  = 5;
   bit m_mode = 0;
   bit m_have = 0;
   bit m_sink = 0;
   bit [6:0] m_hist = '0;
   int now    = 0;
   int m_last = 0;

   always #2.5 clk = ~clk;

   burstcnt_regulator #(.CLK_HZ(CLK_HZ)) i_burstcnt_regulator (
      .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_merged(pkt_merged),
      .vs_strobe(vs_strobe), .vs_under(vs_under), .vs_over(vs_over),
      .sink_clear(sink_clear), .pulse_target(pulse_target), .sink_req(sink_req));

   function automatic int ceil_of(input bit m);
      return m ? 9 : 5;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // One clock cycle of stimulus, model update and comparison.
   task automatic cyc(input bit st, input bit bm, input bit sm, input bit lo,
                      input bit hi, input bit cl);
      string ttag;
      string stag;
      string mtag;
      bit [7:0] w;
      int per;
      int up;
      @(negedge clk);
      pkt_start = st; pkt_merged = bm; vs_strobe = sm;
      vs_under = lo; vs_over = hi; sink_clear = cl;
      @(posedge clk);
      now++;
      ttag = "R2";
      stag = "R10";
      if (st) begin
         if (m_have) begin
            per  = now - m_last;
            up   = (m_mode && m_cnt > 3) ? UPS : UPF;
            mtag = m_mode ? "R7" : "R6";
            if (per >= LR && m_cnt > 1) begin
               m_cnt--; ttag = {"R3/", mtag};
            end else if (per < LR && per <= up && m_cnt < ceil_of(m_mode)) begin
               m_cnt++; ttag = {"R4/", mtag};
            end else begin
               ttag = (per >= LR) ? {"R3/", mtag} : (per <= up) ? {"R4/", mtag} : {"R5/", mtag};
            end
         end
         m_have = 1;
         m_last = now;
      end
      if (sm) begin
         if (lo) m_mode = 0;
         else if (hi) m_mode = 1;
         if (ttag == "R2") ttag = "R8";
      end
      if (m_cnt > ceil_of(m_mode)) begin
         m_cnt = ceil_of(m_mode);
         ttag  = "R9";
      end
      if (cl) begin
         m_hist = '0; m_sink = 0; stag = "R12";
      end else if (st) begin
         w = {m_hist, bm};
         if ($countones(w) >= 2) m_sink = 1;
         else if (w == '0) begin
            if (m_sink) stag = "R11";
            m_sink = 0;
         end
         m_hist = w[6:0];
      end
      #1;
      check(ttag, int'(pulse_target), m_cnt);
      check(stag, int'(sink_req), int'(m_sink));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
   endtask

   // Start a packet `gap` cycles after the previous start.
   task automatic burst(input int gap, input bit bm);
      idle(gap - 1);
      cyc(1, bm, 0, 0, 0, 0);
   endtask

   task automatic sample(input bit lo, input bit hi);
      cyc(0, 0, 1, lo, hi, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", now, 0);
      finish_up();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", int'(pulse_target), 5);
      check("R1", int'(sink_req), 0);

      cyc(1, 0, 0, 0, 0, 0);                 // R2 first start: no step
      check("R2", int'(pulse_target), 5);
      burst(LR, 0);                          // R3 at exact boundary
      burst(LR - 1, 0);                      // R5 one short of it
      for (int i = 0; i < 5; i++) burst(LR + 20, 0);  // R3 down to floor 1
      check("R3", int'(pulse_target), 1);
      burst(UPF + 1, 0);                     // R5 just above fast upper
      burst(UPF, 0);                         // R4 exact
      for (int i = 0; i < 5; i++) burst(150, 0);      // R6 ceiling 5
      check("R6", int'(pulse_target), 5);
      burst(UPS, 0);                         // R6 slow upper unused in low mode
      sample(0, 1);                          // R8 to high mode
      for (int i = 0; i < 5; i++) burst(150, 0);      // R7 ceiling 9
      check("R7", int'(pulse_target), 9);
      for (int i = 0; i < 6; i++) burst(LR + 1, 0);   // down to 3
      burst(250, 0);                         // R7 fast upper at 3: hold
      check("R7", int'(pulse_target), 3);
      burst(150, 0);                         // 4
      burst(UPS, 0);                         // R7 slow upper at 4: step to 5
      burst(UPS + 1, 0);                     // R5 hold at 5
      check("R7", int'(pulse_target), 5);
      sample(0, 0);                          // R8 band: hold high
      cyc(0, 0, 0, 1, 0, 0);                 // R8 no strobe: ignored
      burst(150, 0);                         // 6 proves high mode kept
      check("R8", int'(pulse_target), 6);
      sample(1, 1);                          // R9 under wins, clamp to 5
      check("R9", int'(pulse_target), 5);

      burst(300, 1); burst(300, 0); burst(300, 0); burst(300, 1);  // R10
      check("R10", int'(sink_req), 1);
      for (int i = 0; i < 7; i++) burst(300, 0);
      check("R11", int'(sink_req), 1);
      burst(300, 0);
      check("R11", int'(sink_req), 0);
      burst(300, 1); for (int i = 0; i < 6; i++) burst(300, 0); burst(300, 1); // 7 apart
      check("R10", int'(sink_req), 1);
      cyc(0, 0, 0, 0, 0, 1);
      check("R12", int'(sink_req), 0);
      burst(300, 1);                         // history was emptied: stays low
      check("R12", int'(sink_req), 0);
      idle(299);
      cyc(1, 1, 0, 0, 0, 1);                 // clear wins over start
      burst(300, 1);
      check("R12", int'(sink_req), 0);

      for (int b = 0; b < 200; b++) begin
         int cls;
         int gap;
         cls = $urandom_range(3, 0);
         case (cls)
            0: gap = $urandom_range(UPF, 100);
            1: gap = $urandom_range(UPS, UPF + 1);
            2: gap = $urandom_range(LR - 1, UPS + 1);
            default: gap = $urandom_range(LR + 60, LR);
         endcase
         for (int i = 0; i < gap - 1; i++) begin
            bit sm;
            bit cl;
            sm = ($urandom_range(59, 0) == 0);
            cl = ($urandom_range(399, 0) == 0);
            cyc(0, 0, sm, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), cl);
         end
         cyc(1, ($urandom_range(2, 0) == 0), 0, 0, 0, 0);
      end
      finish_up();
   end
endmodule